// File: doc/BRIEF.md
# Microcode Word Rule Checker

This block watches the control words that a microsequencer applies, one per step, to a single shared-bus datapath. Each word names the registers that drive the bus, the registers (and the ALU input) that capture the bus, an ALU function and a memory operation. On every step strobe the checker evaluates the word against five programming rules and reports each broken rule on its own flag. It never alters or stalls execution.

Four of the rules look at one word alone: two drivers fighting for the bus, a load with nothing driving the bus, an ALU function with the ALU not reading the bus, and the ALU reading the bus with no function selected. The fifth rule spans steps. The checker remembers whether a memory read is still outstanding, and it flags any step that puts the memory data register on the bus before a wait step has retired that read. A sticky summary bit collects every flag raised since reset.

Top module: `mcode_rule_checker`

## Requirements
- R1: In a strobed step where two or more bits of `src_drive` are set, `err_flags[0]` is 1 in the cycle after the strobe.
- R2: In a strobed step where any bit of `dst_load` is set and `src_drive` is all zero, `err_flags[1]` is 1 in the cycle after the strobe; a step with no loads and no drivers raises nothing.
- R3: In a strobed step where `alu_fn` is not 0 (0 none, 1 add, 2 subtract, 3 increment, 4 decrement) and `dst_load[1]` (bus to ALU) is 0, `err_flags[2]` is 1 in the cycle after the strobe.
- R4: In a strobed step where `dst_load[1]` is 1 and `alu_fn` is 0, `err_flags[3]` is 1 in the cycle after the strobe.
- R5: A strobed step with `mem_fn` = 1 (read; 0 idle, 2 write, 3 wait) leaves a read outstanding; a later strobed step with `src_drive[5]` (memory data register to bus) set while that read is outstanding raises `err_flags[4]` in the next cycle, even when that same step carries the wait.
- R6: A strobed step with `mem_fn` = 3 retires the outstanding read, so a later step driving `src_drive[5]` raises no `err_flags[4]`.
- R7: Each flag is high only in the single cycle after the strobed step that raised it; in a cycle not following a strobe all flags are 0.
- R8: `err_any` becomes 1 in the cycle any flag is 1 and stays 1 until reset; it stays 0 while only clean steps run.
- R9: While `rst` is high (synchronous, active high) and in the cycle after, `err_flags` and `err_any` are 0 and no read is outstanding.
- R10: When `step_valid` is 0 the control word is ignored: it raises no flag and a read on it leaves no read outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | Strobe: the word on the other inputs is one executed step |
| src_drive | input | SRC_W (6) | Bus drivers: 0 instruction address field, 1 result, 2 program counter, 3 user reg A, 4 user reg B, 5 memory data register |
| dst_load | input | DST_W (8) | Bus loads: 0 instruction, 1 ALU input, 2 program counter, 3 user reg A, 4 user reg B, 5 operand, 6 memory address, 7 memory data |
| alu_fn | input | 3 | ALU function, 0 means none |
| mem_fn | input | 2 | Memory operation: 0 idle, 1 read, 2 write, 3 wait |
| err_flags | output | 5 | Per-rule pulses: 0 contention, 1 undriven load, 2 ALU without input, 3 input without function, 4 missing wait |
| err_any | output | 1 | Sticky OR of all flags since reset |

## Verification
The hardest case is the missing-wait rule, because its trigger depends on history that is invisible at the ports: whether a read was issued and not yet retired. The bench reaches it by issuing a read step, then an unrelated write step, then a step that both drives the memory data register and carries the wait, which must still be flagged because the wait retires the read only at the end of that step. It also applies a read on a non-strobed cycle and shows, through a following data-register step that stays clean, that no read was recorded.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int SRC_W_DEF   = 6;
    localparam int DST_W_DEF   = 8;
    localparam int SRC_MBR_DEF = 5;
    localparam int DST_ALU_DEF = 1;
    localparam int ERR_W       = 5;

    typedef enum logic [2:0] {
        ALU_NONE = 3'd0,
        ALU_ADD  = 3'd1,
        ALU_SUB  = 3'd2,
        ALU_INC  = 3'd3,
        ALU_DEC  = 3'd4
    } alu_fn_e;

    typedef enum logic [1:0] {
        MEM_IDLE  = 2'd0,
        MEM_READ  = 2'd1,
        MEM_WRITE = 2'd2,
        MEM_WAIT  = 2'd3
    } mem_fn_e;

    // packed: last field is bit 0
    typedef struct packed {
        logic nowait;
        logic alu_nofn;
        logic alu_noin;
        logic undriven;
        logic contend;
    } rule_hits_t;

    function automatic logic alu_selected(input logic [2:0] fn);
        return fn != 3'(ALU_NONE);
    endfunction

endpackage

// File: rtl/mcc_rule_eval.sv
module mcc_rule_eval
    import mcc_pkg::*;
#(
    parameter int SRC_W   = SRC_W_DEF,
    parameter int DST_W   = DST_W_DEF,
    parameter int SRC_MBR = SRC_MBR_DEF,
    parameter int DST_ALU = DST_ALU_DEF
) (
    input  logic [SRC_W-1:0] src_drive,
    input  logic [DST_W-1:0] dst_load,
    input  logic [2:0]       alu_fn,
    input  logic             rd_pending,
    output rule_hits_t       hits
);
    logic [SRC_W-1:0] src_less_low;
    logic             alu_reads_bus;

    always_comb begin
        src_less_low  = src_drive & (src_drive - SRC_W'(1));
        alu_reads_bus = dst_load[DST_ALU];

        hits          = '0;
        hits.contend  = |src_less_low;
        hits.undriven = (|dst_load) && !(|src_drive);
        hits.alu_noin = alu_selected(alu_fn) && !alu_reads_bus;
        hits.alu_nofn = alu_reads_bus && !alu_selected(alu_fn);
        hits.nowait   = rd_pending && src_drive[SRC_MBR];
    end
endmodule

// File: rtl/mcc_read_tracker.sv
module mcc_read_tracker
    import mcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       step_valid,
    input  logic [1:0] mem_fn,
    output logic       rd_pending
);
    mem_fn_e op;
    assign op = mem_fn_e'(mem_fn);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pending <= 1'b0;
        end else if (step_valid) begin
            if (op == MEM_READ) begin
                rd_pending <= 1'b1;
            end else if (op == MEM_WAIT) begin
                rd_pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mcc_flag_reg.sv
module mcc_flag_reg
    import mcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step_valid,
    input  rule_hits_t       hits,
    output logic [ERR_W-1:0] err_flags,
    output logic             err_any
);
    logic [ERR_W-1:0] hit_vec;
    assign hit_vec = hits;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_flags <= '0;
            err_any   <= 1'b0;
        end else begin
            err_flags <= step_valid ? hit_vec : '0;
            if (step_valid && (|hit_vec)) begin
                err_any <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mcode_rule_checker.sv
module mcode_rule_checker
    import mcc_pkg::*;
#(
    parameter int SRC_W   = SRC_W_DEF,
    parameter int DST_W   = DST_W_DEF,
    parameter int SRC_MBR = SRC_MBR_DEF,
    parameter int DST_ALU = DST_ALU_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_valid,
    input  logic [SRC_W-1:0] src_drive,
    input  logic [DST_W-1:0] dst_load,
    input  logic [2:0]       alu_fn,
    input  logic [1:0]       mem_fn,
    output logic [ERR_W-1:0] err_flags,
    output logic             err_any
);
    logic       rd_pending;
    rule_hits_t hits;

    mcc_read_tracker u_trk (
        .clk        (clk),
        .rst        (rst),
        .step_valid (step_valid),
        .mem_fn     (mem_fn),
        .rd_pending (rd_pending)
    );

    mcc_rule_eval #(
        .SRC_W   (SRC_W),
        .DST_W   (DST_W),
        .SRC_MBR (SRC_MBR),
        .DST_ALU (DST_ALU)
    ) u_eval (
        .src_drive  (src_drive),
        .dst_load   (dst_load),
        .alu_fn     (alu_fn),
        .rd_pending (rd_pending),
        .hits       (hits)
    );

    mcc_flag_reg u_flags (
        .clk        (clk),
        .rst        (rst),
        .step_valid (step_valid),
        .hits       (hits),
        .err_flags  (err_flags),
        .err_any    (err_any)
    );
endmodule

// File: rtl/mcode_rule_checker_sva.sv
module mcode_rule_checker_sva
    import mcc_pkg::*;
#(
    parameter int SRC_W   = SRC_W_DEF,
    parameter int DST_W   = DST_W_DEF,
    parameter int SRC_MBR = SRC_MBR_DEF,
    parameter int DST_ALU = DST_ALU_DEF
) (
    input logic             clk,
    input logic             rst,
    input logic             step_valid,
    input logic [SRC_W-1:0] src_drive,
    input logic [DST_W-1:0] dst_load,
    input logic [2:0]       alu_fn,
    input logic [1:0]       mem_fn,
    input logic [ERR_W-1:0] err_flags,
    input logic             err_any,
    input logic             rd_pending
);
    AST_BUS_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        step_valid && ($countones(src_drive) > 1) |=> err_flags[0]); // R1
    AST_UNDRIVEN_LOAD: assert property (@(posedge clk) disable iff (rst)
        step_valid && (|dst_load) && (src_drive == '0) |=> err_flags[1]); // R2
    AST_ALU_NO_INPUT: assert property (@(posedge clk) disable iff (rst)
        step_valid && (alu_fn != 3'd0) && !dst_load[DST_ALU] |=> err_flags[2]); // R3
    AST_ALU_NO_FUNC: assert property (@(posedge clk) disable iff (rst)
        step_valid && dst_load[DST_ALU] && (alu_fn == 3'd0) |=> err_flags[3]); // R4
    AST_READ_RECORDED: assert property (@(posedge clk) disable iff (rst)
        step_valid && (mem_fn == 2'd1) |=> rd_pending); // R5
    AST_MISSING_WAIT: assert property (@(posedge clk) disable iff (rst)
        step_valid && rd_pending && src_drive[SRC_MBR] |=> err_flags[4]); // R5
    AST_WAIT_RETIRES: assert property (@(posedge clk) disable iff (rst)
        step_valid && (mem_fn == 2'd3) |=> !rd_pending); // R6
    AST_PULSE_ONLY: assert property (@(posedge clk) disable iff (rst)
        !step_valid |=> (err_flags == '0)); // R7
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        err_any |=> err_any); // R8
    AST_STICKY_COVERS: assert property (@(posedge clk) disable iff (rst)
        (|err_flags) |-> err_any); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (err_flags == '0) && !err_any && !rd_pending); // R9
    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        !step_valid && !rd_pending |=> !rd_pending); // R10
endmodule

bind mcode_rule_checker mcode_rule_checker_sva #(
    .SRC_W   (SRC_W),
    .DST_W   (DST_W),
    .SRC_MBR (SRC_MBR),
    .DST_ALU (DST_ALU)
) u_sva (
    .clk        (clk),
    .rst        (rst),
    .step_valid (step_valid),
    .src_drive  (src_drive),
    .dst_load   (dst_load),
    .alu_fn     (alu_fn),
    .mem_fn     (mem_fn),
    .err_flags  (err_flags),
    .err_any    (err_any),
    .rd_pending (rd_pending)
);

// File: tb/test_mcode_rule_checker.sv
module test_mcode_rule_checker;
    // source bits
    localparam logic [5:0] S_IRA = 6'b000001, S_RES = 6'b000010, S_PC = 6'b000100,
                           S_RA  = 6'b001000, S_RB  = 6'b010000, S_MBR = 6'b100000;
    // load bits
    localparam logic [7:0] D_IR = 8'h01, D_ALU = 8'h02, D_PC = 8'h04, D_RA = 8'h08,
                           D_RB = 8'h10, D_OPN = 8'h20, D_MAR = 8'h40, D_MBR = 8'h80;
    localparam logic [1:0] M_IDLE = 2'd0, M_RD = 2'd1, M_WR = 2'd2, M_WT = 2'd3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_valid = 1'b0;
    logic [5:0] src_drive = '0;
    logic [7:0] dst_load = '0;
    logic [2:0] alu_fn = '0;
    logic [1:0] mem_fn = '0;
    logic [4:0] err_flags;
    logic       err_any;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mcode_rule_checker i_mcode_rule_checker (
        .clk(clk), .rst(rst), .step_valid(step_valid), .src_drive(src_drive),
        .dst_load(dst_load), .alu_fn(alu_fn), .mem_fn(mem_fn),
        .err_flags(err_flags), .err_any(err_any)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // apply one strobed word at a falling edge; return one cycle later
    task automatic step(input logic [5:0] s, input logic [7:0] d,
                        input logic [2:0] a, input logic [1:0] m);
        src_drive = s; dst_load = d; alu_fn = a; mem_fn = m; step_valid = 1'b1;
        @(negedge clk);
        step_valid = 1'b0; src_drive = '0; dst_load = '0; alu_fn = '0; mem_fn = '0;
    endtask

    task automatic t_reset;
        chk("R9 flags in reset", 32'(err_flags), 0);
        chk("R9 sticky in reset", 32'(err_any), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 flags after reset", 32'(err_flags), 0);
    endtask

    task automatic t_clean_fetch;
        step(S_PC, D_MAR | D_ALU, 3'd3, M_RD);
        chk("R1 R4 clean fetch step", 32'(err_flags), 0);
        step(S_RES, D_PC, 3'd0, M_WT);
        chk("R2 R3 clean writeback with wait", 32'(err_flags), 0);
        step(S_MBR, D_IR, 3'd0, M_IDLE);
        chk("R6 data register after wait", 32'(err_flags), 0);
        step(6'b0, 8'b0, 3'd0, M_IDLE);
        chk("R2 empty step", 32'(err_flags), 0);
        chk("R8 sticky stays low", 32'(err_any), 0);
    endtask

    task automatic t_contention;
        step(S_PC | S_RA, D_MAR, 3'd0, M_IDLE);
        chk("R1 two drivers", 32'(err_flags), 32'h01);
        chk("R8 sticky set", 32'(err_any), 1);
        @(negedge clk);
        chk("R7 flag drops", 32'(err_flags), 0);
        step(S_IRA | S_RES | S_RB, D_RA, 3'd0, M_IDLE);
        chk("R1 three drivers", 32'(err_flags), 32'h01);
    endtask

    task automatic t_undriven;
        step(6'b0, D_RA, 3'd0, M_IDLE);
        chk("R2 load without driver", 32'(err_flags), 32'h02);
        step(S_RB, D_OPN, 3'd0, M_IDLE);
        chk("R7 back-to-back clean step", 32'(err_flags), 0);
    endtask

    task automatic t_alu;
        step(S_RB, D_OPN, 3'd1, M_IDLE);
        chk("R3 add without bus input", 32'(err_flags), 32'h04);
        step(S_IRA, D_ALU, 3'd0, M_IDLE);
        chk("R4 bus input without function", 32'(err_flags), 32'h08);
        step(6'b0, D_ALU, 3'd0, M_IDLE);
        chk("R2 R4 combined", 32'(err_flags), 32'h0A);
        step(S_MBR, D_ALU, 3'd2, M_IDLE);
        chk("R3 R4 subtract with input ok", 32'(err_flags), 0);
    endtask

    task automatic t_wait;
        step(S_PC, D_MAR, 3'd0, M_RD);
        chk("R5 read issue clean", 32'(err_flags), 0);
        step(S_MBR, D_IR, 3'd0, M_IDLE);
        chk("R5 data register before wait", 32'(err_flags), 32'h10);
        step(6'b0, 8'b0, 3'd0, M_WT);
        step(S_MBR, D_IR, 3'd0, M_IDLE);
        chk("R6 wait retires read", 32'(err_flags), 0);
        step(S_RES, D_MAR, 3'd0, M_RD);
        step(S_RA, D_MBR, 3'd0, M_WR);
        chk("R5 write step while pending", 32'(err_flags), 0);
        step(S_MBR, D_IR, 3'd0, M_WT);
        chk("R5 wait in same step still late", 32'(err_flags), 32'h10);
        step(S_MBR, D_IR, 3'd0, M_IDLE);
        chk("R6 retired by that wait", 32'(err_flags), 0);
    endtask

    task automatic t_ignore;
        src_drive = S_PC | S_RA; dst_load = D_ALU; alu_fn = 3'd0; mem_fn = M_RD;
        @(negedge clk);
        chk("R10 unstrobed bad word", 32'(err_flags), 0);
        src_drive = '0; dst_load = '0; mem_fn = '0;
        step(S_MBR, D_IR, 3'd0, M_IDLE);
        chk("R10 unstrobed read not recorded", 32'(err_flags), 0);
    endtask

    task automatic t_sticky_reset;
        step(S_PC, D_MAR, 3'd0, M_RD);
        step(S_RES, D_PC, 3'd0, M_IDLE);
        chk("R8 sticky held", 32'(err_any), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 sticky cleared", 32'(err_any), 0);
        step(S_MBR, D_IR, 3'd0, M_IDLE);
        chk("R9 reset drops pending read", 32'(err_flags), 0);
        chk("R9 sticky still clear", 32'(err_any), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_clean_fetch();
        t_contention();
        t_undriven();
        t_alu();
        t_wait();
        t_ignore();
        t_sticky_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule